// File: doc/BRIEF.md
# Parity-Protected Dual-Port Shared RAM Access

This block sits in front of a single-ported shared RAM that stores 16 data bits plus one parity bit per word. Two requesters reach it: the host processor and the block's own internal logic. Both use the same simple request interface, and the internal port takes priority. On every write a parity bit is computed and stored beside the data. On every read the full stored word is checked, whichever port made the access.

When a read finds bad parity, the block sets a sticky status flag and pulses an interrupt for one cycle. It also presents the failing address, tagged with the port that read it. When logging is enabled, a valid strobe goes with that address so a downstream interrupt status queue can record it. A test input inverts the parity bit as it is written, so software or a bench can plant errors on purpose and confirm that the checker responds.

Top module: `par_ram_port`

## Requirements
- R1: On a write, bit 16 of the stored word is the odd-parity bit over the 16 data bits, so that the 17 stored bits hold an odd number of ones. A read of that word returns the written data, and no error follows.
- R2: A granted read returns its data on the rdata output of the requesting port, with that port's rvalid high, exactly one cycle after the request cycle.
- R3: When both ports request in the same cycle, the internal access is performed and host_wait_o is high in that cycle. host_wait_o is low whenever the internal port is not requesting.
- R4: Parity is checked on every read from either port. A read of a word whose 17 bits hold an even number of ones sets err_sticky_o one cycle after the data returns.
- R5: err_irq_o is high for exactly one cycle for each failing read, in the same cycle that err_sticky_o first reflects that error.
- R6: err_sticky_o stays high until err_clr_i is asserted. If a new error and a clear arrive in the same cycle, the error wins.
- R7: A clear with no new error drops err_sticky_o in the next cycle.
- R8: With each error, err_addr_o holds the failing address and err_port_o holds the port that read it (1 = host, 0 = internal). err_addr_vld_o pulses with err_irq_o only if log_en_i was high in the cycle the data returned.
- R9: With par_flip_i high during a write, the stored parity bit is inverted, and a later read of that word reports an error.
- R10: An all-zero data word whose stored parity bit is zero is reported as a parity error.
- R11: Writes produce no rvalid on either port, and at most one port's rvalid is high in any cycle.
- R12: Read data is returned unchanged even when its parity is bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | DW | Host write data |
| host_wait_o | output | 1 | Host request stalled this cycle |
| host_rvalid_o | output | 1 | Host read data valid |
| host_rdata_o | output | DW | Host read data |
| int_req_i | input | 1 | Internal access request |
| int_we_i | input | 1 | Internal write enable |
| int_addr_i | input | AW | Internal word address |
| int_wdata_i | input | DW | Internal write data |
| int_rvalid_o | output | 1 | Internal read data valid |
| int_rdata_o | output | DW | Internal read data |
| par_flip_i | input | 1 | Invert the parity bit on writes (test) |
| log_en_i | input | 1 | Enable the error address valid strobe |
| err_clr_i | input | 1 | Clear the sticky error flag |
| err_sticky_o | output | 1 | Sticky parity error status |
| err_irq_o | output | 1 | One-cycle interrupt pulse per error |
| err_addr_o | output | AW | Address of the last failing read |
| err_port_o | output | 1 | Port of the last failing read (1 = host) |
| err_addr_vld_o | output | 1 | Strobe to log err_addr_o |

## Verification
The assertions assume that a stalled host holds its request steady until host_wait_o falls. They also assume that the RAM word at any address is read only after it has been written, because unwritten words have undefined parity. The bench writes every address before reading it and keeps the host request held through a stall. Errors are planted only through par_flip_i, so each error cycle and address the bench expects is known in advance.

// File: rtl/par_ram_pkg.sv
package par_ram_pkg;
  typedef enum logic {
    PORT_INT  = 1'b0,
    PORT_HOST = 1'b1
  } port_e;
endpackage

// File: rtl/par_ram_arb.sv
module par_ram_arb
  import par_ram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          int_req_i,
  input  logic          int_we_i,
  input  logic [AW-1:0] int_addr_i,
  input  logic [DW-1:0] int_wdata_i,
  output logic          acc_en_o,
  output logic          acc_we_o,
  output logic [AW-1:0] acc_addr_o,
  output logic [DW-1:0] acc_wdata_o,
  output port_e         acc_port_o,
  output logic          host_wait_o
);
  // internal port always wins
  always_comb begin
    acc_en_o    = int_req_i | host_req_i;
    host_wait_o = int_req_i & host_req_i;
    if (int_req_i) begin
      acc_we_o    = int_we_i;
      acc_addr_o  = int_addr_i;
      acc_wdata_o = int_wdata_i;
      acc_port_o  = PORT_INT;
    end else begin
      acc_we_o    = host_we_i;
      acc_addr_o  = host_addr_i;
      acc_wdata_o = host_wdata_i;
      acc_port_o  = PORT_HOST;
    end
  end
endmodule

// File: rtl/par_ram_par.sv
module par_ram_par #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] wdata_i,
  input  logic          flip_i,
  output logic [DW:0]   wword_o,
  input  logic [DW:0]   rword_i,
  output logic          rbad_o
);
  // odd parity: stored word has an odd count of ones
  assign wword_o = {(~(^wdata_i)) ^ flip_i, wdata_i};
  assign rbad_o  = ~(^rword_i);
endmodule

// File: rtl/par_ram_mem.sv
module par_ram_mem
  import par_ram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW:0]   wword_i,
  input  port_e         port_i,
  output logic          rvld_o,
  output logic [DW:0]   rword_o,
  output logic [AW-1:0] raddr_o,
  output port_e         rport_o
);
  localparam int Depth = 1 << AW;

  logic [DW:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[addr_i] <= wword_i;
    if (en_i && !we_i) begin
      rword_o <= mem_q[addr_i];
      raddr_o <= addr_i;
      rport_o <= port_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvld_o <= 1'b0;
    else         rvld_o <= en_i & ~we_i;
  end
endmodule

// File: rtl/par_ram_err.sv
module par_ram_err
  import par_ram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rvld_i,
  input  logic          rbad_i,
  input  logic [AW-1:0] raddr_i,
  input  port_e         rport_i,
  input  logic          log_en_i,
  input  logic          clr_i,
  output logic          sticky_o,
  output logic          irq_o,
  output logic [AW-1:0] addr_o,
  output logic          port_o,
  output logic          addr_vld_o
);
  logic hit;
  assign hit = rvld_i & rbad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_o   <= 1'b0;
      irq_o      <= 1'b0;
      addr_vld_o <= 1'b0;
      addr_o     <= '0;
      port_o     <= 1'b0;
    end else begin
      irq_o      <= hit;
      addr_vld_o <= hit & log_en_i;
      sticky_o   <= hit | (sticky_o & ~clr_i); // set wins over clear
      if (hit) begin
        addr_o <= raddr_i;
        port_o <= (rport_i == PORT_HOST);
      end
    end
  end
endmodule

// File: rtl/par_ram_port.sv
module par_ram_port
  import par_ram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic          host_wait_o,
  output logic          host_rvalid_o,
  output logic [DW-1:0] host_rdata_o,
  input  logic          int_req_i,
  input  logic          int_we_i,
  input  logic [AW-1:0] int_addr_i,
  input  logic [DW-1:0] int_wdata_i,
  output logic          int_rvalid_o,
  output logic [DW-1:0] int_rdata_o,
  input  logic          par_flip_i,
  input  logic          log_en_i,
  input  logic          err_clr_i,
  output logic          err_sticky_o,
  output logic          err_irq_o,
  output logic [AW-1:0] err_addr_o,
  output logic          err_port_o,
  output logic          err_addr_vld_o
);
  logic          acc_en, acc_we, rvld, rbad;
  logic [AW-1:0] acc_addr, raddr;
  logic [DW-1:0] acc_wdata;
  logic [DW:0]   wword, rword;
  port_e         acc_port, rport;

  par_ram_arb #(.AW(AW), .DW(DW)) u_arb (
    .host_req_i, .host_we_i, .host_addr_i, .host_wdata_i,
    .int_req_i, .int_we_i, .int_addr_i, .int_wdata_i,
    .acc_en_o(acc_en), .acc_we_o(acc_we), .acc_addr_o(acc_addr),
    .acc_wdata_o(acc_wdata), .acc_port_o(acc_port), .host_wait_o
  );

  par_ram_par #(.DW(DW)) u_par (
    .wdata_i(acc_wdata), .flip_i(par_flip_i), .wword_o(wword),
    .rword_i(rword), .rbad_o(rbad)
  );

  par_ram_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i, .rst_ni, .en_i(acc_en), .we_i(acc_we), .addr_i(acc_addr),
    .wword_i(wword), .port_i(acc_port), .rvld_o(rvld), .rword_o(rword),
    .raddr_o(raddr), .rport_o(rport)
  );

  par_ram_err #(.AW(AW)) u_err (
    .clk_i, .rst_ni, .rvld_i(rvld), .rbad_i(rbad), .raddr_i(raddr),
    .rport_i(rport), .log_en_i, .clr_i(err_clr_i), .sticky_o(err_sticky_o),
    .irq_o(err_irq_o), .addr_o(err_addr_o), .port_o(err_port_o),
    .addr_vld_o(err_addr_vld_o)
  );

  assign host_rvalid_o = rvld & (rport == PORT_HOST);
  assign int_rvalid_o  = rvld & (rport == PORT_INT);
  assign host_rdata_o  = rword[DW-1:0];
  assign int_rdata_o   = rword[DW-1:0];
endmodule

// File: rtl/par_ram_port_chk.sv
module par_ram_port_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_req_i,
  input logic          host_we_i,
  input logic          host_wait_o,
  input logic          host_rvalid_o,
  input logic          int_req_i,
  input logic          int_we_i,
  input logic          int_rvalid_o,
  input logic          err_clr_i,
  input logic          err_sticky_o,
  input logic          err_irq_o,
  input logic          err_addr_vld_o
);
  p_host_rd_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_we_i && !host_wait_o |=> host_rvalid_o);
  p_int_rd_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_i && !int_we_i |=> int_rvalid_o);
  p_no_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_req_i |-> !host_wait_o);
  p_irq_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> err_sticky_o);
  p_sticky_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sticky_o && !err_clr_i |=> err_sticky_o);
  p_clr_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> err_irq_o || !err_sticky_o);
  p_vld_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_addr_vld_o |-> err_irq_o);
  p_wr_no_rvld_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_i && int_we_i |=> !int_rvalid_o && !host_rvalid_o);
  p_one_rvld_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({host_rvalid_o, int_rvalid_o}));
endmodule

bind par_ram_port par_ram_port_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/par_ram_port_tb_top.sv
module par_ram_port_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          host_req = 0, host_we = 0, int_req = 0, int_we = 0;
  logic [AW-1:0] host_addr = '0, int_addr = '0;
  logic [DW-1:0] host_wdata = '0, int_wdata = '0;
  logic          par_flip = 0, log_en = 0, err_clr = 0;
  logic          host_wait, host_rvalid, int_rvalid;
  logic [DW-1:0] host_rdata, int_rdata;
  logic          err_sticky, err_irq, err_port, err_addr_vld;
  logic [AW-1:0] err_addr;

  int errors = 0, checks = 0;
  bit done = 0;

  par_ram_port #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_wait_o(host_wait),
    .host_rvalid_o(host_rvalid), .host_rdata_o(host_rdata),
    .int_req_i(int_req), .int_we_i(int_we), .int_addr_i(int_addr),
    .int_wdata_i(int_wdata), .int_rvalid_o(int_rvalid), .int_rdata_o(int_rdata),
    .par_flip_i(par_flip), .log_en_i(log_en), .err_clr_i(err_clr),
    .err_sticky_o(err_sticky), .err_irq_o(err_irq), .err_addr_o(err_addr),
    .err_port_o(err_port), .err_addr_vld_o(err_addr_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic flip);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d; par_flip = flip;
    tick();
    host_req = 0; host_we = 0; par_flip = 0;
  endtask

  task automatic int_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic flip);
    int_req = 1; int_we = 1; int_addr = a; int_wdata = d; par_flip = flip;
    tick();
    chk("R11 write rvalid", {host_rvalid, int_rvalid}, 0);
    int_req = 0; int_we = 0; par_flip = 0;
  endtask

  // returns after the data cycle; caller is one cycle before error outputs
  task automatic host_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    host_req = 1; host_we = 0; host_addr = a;
    tick();
    host_req = 0;
    chk({req, " host rvalid"}, host_rvalid, 1);
    chk({req, " host rdata"}, host_rdata, exp);
  endtask

  task automatic int_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    int_req = 1; int_we = 0; int_addr = a;
    tick();
    int_req = 0;
    chk({req, " int rvalid"}, int_rvalid, 1);
    chk({req, " int rdata"}, int_rdata, exp);
  endtask

  task automatic t_reset();
    chk("R5 reset irq", err_irq, 0);
    chk("R6 reset sticky", err_sticky, 0);
    chk("R8 reset vld", err_addr_vld, 0);
    chk("R11 reset rvalid", {host_rvalid, int_rvalid}, 0);
  endtask

  task automatic t_basic();
    host_wr(8'h10, 16'hA5A5, 0);
    host_wr(8'h11, 16'h0001, 0);
    int_wr(8'h20, 16'h0000, 0);
    host_rd(8'h10, 16'hA5A5, "R1 R2");
    tick();
    chk("R1 no error", err_sticky, 0);
    int_rd(8'h11, 16'h0001, "R2");
    int_rd(8'h20, 16'h0000, "R1 zero");
    tick();
    chk("R4 no error", err_irq, 0);
  endtask

  task automatic t_collide();
    int_req = 1; int_we = 1; int_addr = 8'h30; int_wdata = 16'h1234;
    host_req = 1; host_we = 0; host_addr = 8'h10;
    #1;
    chk("R3 wait on collision", host_wait, 1);
    tick();
    int_req = 0; int_we = 0;
    chk("R3 host not served", host_rvalid, 0);
    #1;
    chk("R3 no wait alone", host_wait, 0);
    tick();
    host_req = 0;
    chk("R3 host served", host_rvalid, 1);
    chk("R3 host rdata", host_rdata, 16'hA5A5);
    host_rd(8'h30, 16'h1234, "R3 internal write done");
  endtask

  task automatic t_flip_host();
    log_en = 1;
    host_wr(8'h42, 16'h00F3, 1);
    host_rd(8'h42, 16'h00F3, "R12 R9");
    tick();
    log_en = 0;
    chk("R4 sticky", err_sticky, 1);
    chk("R5 irq", err_irq, 1);
    chk("R8 addr", err_addr, 8'h42);
    chk("R8 port host", err_port, 1);
    chk("R8 vld", err_addr_vld, 1);
    tick();
    chk("R5 irq one cycle", err_irq, 0);
    chk("R8 vld one cycle", err_addr_vld, 0);
    repeat (3) tick();
    chk("R6 sticky held", err_sticky, 1);
    err_clr = 1; tick(); err_clr = 0;
    chk("R7 cleared", err_sticky, 0);
  endtask

  task automatic t_zero_int();
    log_en = 0;
    int_wr(8'h55, 16'h0000, 1); // stored 17'h0
    int_rd(8'h55, 16'h0000, "R10");
    tick();
    chk("R10 zero word flagged", err_irq, 1);
    chk("R8 port internal", err_port, 0);
    chk("R8 addr", err_addr, 8'h55);
    chk("R8 no vld when disabled", err_addr_vld, 0);
    // clear coinciding with a new error: error wins
    int_req = 1; int_we = 0; int_addr = 8'h55;
    tick();
    int_req = 0; err_clr = 1;
    tick();
    err_clr = 0;
    chk("R6 set beats clear", err_sticky, 1);
    chk("R5 second pulse", err_irq, 1);
    err_clr = 1; tick(); err_clr = 0;
    chk("R7 cleared again", err_sticky, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_basic();
    t_collide();
    t_flip_host();
    t_zero_int();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule